// File: doc/BRIEF.md
# Flash Command Snoop Sequencer

This block sits beside the transmit byte stream of a serial flash master and classifies every byte sent while a chip select is active. The first byte after select is taken as an opcode; the block decodes it on the fly, then steps through the address bytes, the dummy bytes and finally the data bytes of that command. From the decoded opcode it works out how many serial lanes (1, 2 or 4) each byte uses and how many serial clock cycles a byte occupies.

Two kinds of lane switch exist. The I/O read commands widen the bus at once after the opcode, so address and dummy bytes already use the wide lanes. The output-read and multi-lane program commands keep one lane for address and dummy bytes and widen only from the first data byte on. Dummy bytes are flagged so that the shifter sends them as 8/width clock cycles and captures nothing. An opcode the block does not know puts it in a pass-through phase with one lane until select is released.

The shifter consults the outputs before sending a byte; the byte strobe then advances the state for the byte that follows.

Top module: `flash_cmd_snoop`

## Requirements
- R1: After reset, and one cycle after cs_active_i is low, phase_o is 0 (opcode), lane_width_o is 1 and any scheduled lane switch is cancelled; a byte strobe while cs_active_i is low has no effect.
- R2: phase_o encodes 0 opcode, 1 address, 2 dummy, 3 data, 4 pass-through; dummy_o is high exactly in the dummy phase; cycles_o equals 8 divided by lane_width_o, and lane_width_o is always 1, 2 or 4.
- R3: Opcodes 0x13, 0x12, 0x34, 0x0C, 0x3C, 0x6C, 0xBC and 0xEC always take 4 address bytes; every other known opcode takes 4 when ext_addr_i is high at the opcode byte and 3 otherwise.
- R4: Dummy byte counts: 0 for 0x03, 0x02, 0xA2, 0x32, 0x13, 0x12, 0x34; 1 for 0x0B, 0x3B, 0x6B, 0x3C, 0x6C; 2 for 0xBB, 0x0C, 0xBC; 5 for 0xEB, 0xEC. After the last address byte the phase moves to dummy (or straight to data with no dummies), and after the last dummy byte to data.
- R5: Any opcode not listed in R4 moves the phase to pass-through, where it stays with lane width 1 until select is released.
- R6: Opcodes 0x3B, 0xA2, 0x3C select 2 lanes and 0x6B, 0x32, 0x34, 0x6C select 4 lanes starting with the first data byte; all address and dummy bytes before it use 1 lane.
- R7: Opcodes 0xBB, 0xBC select 2 lanes and 0xEB, 0xEC select 4 lanes from the first address byte on.
- R8: While cs_active_i is high and byte_valid_i is low, phase, lane width and byte position do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_valid_i | input | 1 | A byte is being transmitted this cycle |
| byte_i | input | 8 | The transmitted byte |
| cs_active_i | input | 1 | A chip select is asserted |
| ext_addr_i | input | 1 | Use 4 address bytes for opcodes without a fixed 4-byte form |
| lane_width_o | output | 3 | Lanes for the current byte: 1, 2 or 4 |
| dummy_o | output | 1 | Current byte is a dummy byte |
| cycles_o | output | 4 | Serial clock cycles for the current byte |
| phase_o | output | 3 | Current byte class (encoding in R2) |

## Verification
A deferred lane switch and the move from the dummy (or address) phase into the data phase are both triggered by the same byte strobe, so the first data byte must see the new phase and the new width together. Every command type is run with random trailing lengths and random idle gaps, and at each byte boundary the bench compares phase, width, dummy flag and cycle count against an independent per-byte model; a select release straight after a scheduling opcode checks that a pending switch cannot leak into the next command.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  localparam int BYTE_W  = 8;
  localparam int LANE_W  = 3;
  localparam int DUM_W   = 3;
  localparam int CYC_W   = 4;

  typedef enum logic [2:0] {
    PH_OPCODE = 3'd0,
    PH_ADDR   = 3'd1,
    PH_DUMMY  = 3'd2,
    PH_DATA   = 3'd3,
    PH_PASS   = 3'd4
  } phase_e;

  typedef enum logic [1:0] {
    SW_NONE  = 2'd0,
    SW_DEFER = 2'd1,
    SW_NOW   = 2'd2
  } switch_e;

  typedef struct packed {
    logic              known;
    logic              addr4;
    logic [DUM_W-1:0]  dummies;
    switch_e           sw;
    logic [LANE_W-1:0] width;
  } op_info_t;
endpackage

// File: rtl/fcs_op_decode.sv
module fcs_op_decode
  import fcs_pkg::*;
(
  input  logic [BYTE_W-1:0] opcode_i,
  output op_info_t          info_o
);
  always_comb begin
    info_o = '{known: 1'b1, addr4: 1'b0, dummies: '0, sw: SW_NONE, width: LANE_W'(1)};
    unique case (opcode_i)
      8'h03, 8'h02: ;
      8'h0B: info_o.dummies = 3'd1;
      8'h3B: begin info_o.dummies = 3'd1; info_o.sw = SW_DEFER; info_o.width = 3'd2; end
      8'h6B: begin info_o.dummies = 3'd1; info_o.sw = SW_DEFER; info_o.width = 3'd4; end
      8'hA2: begin info_o.sw = SW_DEFER; info_o.width = 3'd2; end
      8'h32: begin info_o.sw = SW_DEFER; info_o.width = 3'd4; end
      8'hBB: begin info_o.dummies = 3'd2; info_o.sw = SW_NOW; info_o.width = 3'd2; end
      8'hEB: begin info_o.dummies = 3'd5; info_o.sw = SW_NOW; info_o.width = 3'd4; end
      8'h13, 8'h12: info_o.addr4 = 1'b1;
      8'h0C: begin info_o.addr4 = 1'b1; info_o.dummies = 3'd2; end
      8'h34: begin info_o.addr4 = 1'b1; info_o.sw = SW_DEFER; info_o.width = 3'd4; end
      8'h3C: begin info_o.addr4 = 1'b1; info_o.dummies = 3'd1; info_o.sw = SW_DEFER; info_o.width = 3'd2; end
      8'h6C: begin info_o.addr4 = 1'b1; info_o.dummies = 3'd1; info_o.sw = SW_DEFER; info_o.width = 3'd4; end
      8'hBC: begin info_o.addr4 = 1'b1; info_o.dummies = 3'd2; info_o.sw = SW_NOW; info_o.width = 3'd2; end
      8'hEC: begin info_o.addr4 = 1'b1; info_o.dummies = 3'd5; info_o.sw = SW_NOW; info_o.width = 3'd4; end
      default: info_o.known = 1'b0;
    endcase
  end
endmodule

// File: rtl/fcs_phase_track.sv
module fcs_phase_track
  import fcs_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             step_i,
  input  logic             known_i,
  input  logic [DUM_W-1:0] dummies_i,
  input  logic [2:0]       addr_len_i,
  output phase_e           phase_o
);
  phase_e           phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic [DUM_W-1:0] dum_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_OPCODE;
      cnt_q   <= '0;
      dum_q   <= '0;
    end else if (clear_i) begin
      phase_q <= PH_OPCODE;
      cnt_q   <= '0;
      dum_q   <= '0;
    end else if (step_i) begin
      unique case (phase_q)
        PH_OPCODE: begin
          if (known_i) begin
            phase_q <= PH_ADDR;
            cnt_q   <= CNT_W'(addr_len_i - 3'd1);
            dum_q   <= dummies_i;
          end else begin
            phase_q <= PH_PASS;
          end
        end
        PH_ADDR: begin
          if (cnt_q == '0) begin
            if (dum_q == '0) begin
              phase_q <= PH_DATA;
            end else begin
              phase_q <= PH_DUMMY;
              cnt_q   <= CNT_W'(dum_q - 3'd1);
            end
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        PH_DUMMY: begin
          if (cnt_q == '0) phase_q <= PH_DATA;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign phase_o = phase_q;
endmodule

// File: rtl/fcs_lane_sched.sv
module fcs_lane_sched
  import fcs_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              step_i,
  input  logic              opc_step_i,
  input  switch_e           sw_i,
  input  logic [LANE_W-1:0] target_w_i,
  input  logic [DUM_W-1:0]  dummies_i,
  input  logic [2:0]        addr_len_i,
  output logic [LANE_W-1:0] width_o
);
  logic [LANE_W-1:0] width_q, next_q;
  logic [CNT_W-1:0]  pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      width_q <= LANE_W'(1);
      next_q  <= LANE_W'(1);
      pend_q  <= '0;
    end else if (clear_i) begin
      width_q <= LANE_W'(1);
      next_q  <= LANE_W'(1);
      pend_q  <= '0;
    end else if (step_i) begin
      // deferred switch lands on the byte after the last address/dummy byte
      if (pend_q != '0) begin
        pend_q <= pend_q - 1'b1;
        if (pend_q == CNT_W'(1)) width_q <= next_q;
      end
      if (opc_step_i) begin
        unique case (sw_i)
          SW_DEFER: begin
            next_q <= target_w_i;
            pend_q <= CNT_W'(addr_len_i) + CNT_W'(dummies_i);
          end
          SW_NOW:  width_q <= target_w_i;
          default: ;
        endcase
      end
    end
  end

  assign width_o = width_q;
endmodule

// File: rtl/flash_cmd_snoop.sv
module flash_cmd_snoop
  import fcs_pkg::*;
#(
  parameter int SEQ_W  = 3,
  parameter int PEND_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              byte_valid_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              cs_active_i,
  input  logic              ext_addr_i,
  output logic [LANE_W-1:0] lane_width_o,
  output logic              dummy_o,
  output logic [CYC_W-1:0]  cycles_o,
  output logic [2:0]        phase_o
);
  op_info_t   info;
  phase_e     phase;
  logic       step, clear, opc_step;
  logic [2:0] addr_len;

  assign clear    = !cs_active_i;
  assign step     = cs_active_i && byte_valid_i;
  assign opc_step = step && (phase == PH_OPCODE);
  assign addr_len = (info.addr4 || ext_addr_i) ? 3'd4 : 3'd3;

  fcs_op_decode u_dec (
    .opcode_i (byte_i),
    .info_o   (info)
  );

  fcs_phase_track #(.CNT_W(SEQ_W)) u_phase (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (clear),
    .step_i     (step),
    .known_i    (info.known),
    .dummies_i  (info.dummies),
    .addr_len_i (addr_len),
    .phase_o    (phase)
  );

  fcs_lane_sched #(.CNT_W(PEND_W)) u_lane (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (clear),
    .step_i     (step),
    .opc_step_i (opc_step),
    .sw_i       (info.sw),
    .target_w_i (info.width),
    .dummies_i  (info.dummies),
    .addr_len_i (addr_len),
    .width_o    (lane_width_o)
  );

  always_comb begin
    unique case (lane_width_o)
      3'd2:    cycles_o = CYC_W'(4);
      3'd4:    cycles_o = CYC_W'(2);
      default: cycles_o = CYC_W'(8);
    endcase
  end

  assign dummy_o = (phase == PH_DUMMY);
  assign phase_o = phase;
endmodule

// File: rtl/flash_cmd_snoop_chk.sv
module flash_cmd_snoop_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       byte_valid_i,
  input logic [7:0] byte_i,
  input logic       cs_active_i,
  input logic [2:0] lane_width_o,
  input logic [2:0] phase_o
);
  logic known_op;
  assign known_op = byte_i inside {8'h03, 8'h02, 8'h0B, 8'h3B, 8'h6B, 8'hA2, 8'h32, 8'hBB,
                                   8'hEB, 8'h13, 8'h12, 8'h0C, 8'h34, 8'h3C, 8'h6C, 8'hBC, 8'hEC};

  a_r1_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_active_i |=> (phase_o == 3'd0) && (lane_width_o == 3'd1));

  a_r2_width_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(lane_width_o) == 1 && lane_width_o != 3'd0);

  a_r5_unknown_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_active_i && byte_valid_i && phase_o == 3'd0 && !known_op |=> phase_o == 3'd4);

  a_r5_pass_narrow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_o == 3'd4 |-> lane_width_o == 3'd1);

  a_r7_quad_io_now: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_active_i && byte_valid_i && phase_o == 3'd0 && (byte_i == 8'hEB || byte_i == 8'hEC)
    |=> lane_width_o == 3'd4);

  a_r8_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_active_i && !byte_valid_i |=> $stable(phase_o) && $stable(lane_width_o));
endmodule

bind flash_cmd_snoop flash_cmd_snoop_chk u_chk (.*);

// File: tb/flash_cmd_snoop_tb.sv
module flash_cmd_snoop_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       byte_valid_i = 1'b0;
  logic [7:0] byte_i = 8'h00;
  logic       cs_active_i = 1'b0;
  logic       ext_addr_i = 1'b0;
  logic [2:0] lane_width_o;
  logic       dummy_o;
  logic [3:0] cycles_o;
  logic [2:0] phase_o;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  flash_cmd_snoop dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .byte_valid_i(byte_valid_i), .byte_i(byte_i),
    .cs_active_i(cs_active_i), .ext_addr_i(ext_addr_i), .lane_width_o(lane_width_o),
    .dummy_o(dummy_o), .cycles_o(cycles_o), .phase_o(phase_o)
  );

  task automatic check(input string tag, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  // per-byte expected class and width, from the requirements
  function automatic void model(input logic [7:0] op, input logic ext, input int k,
                                output int ph, output int w, output int kind, output int total_hdr);
    int dum, al, tw;
    logic known, four;
    known = 1'b1; dum = 0; kind = 0; tw = 1; four = 1'b0;
    case (op)
      8'h03, 8'h02: ;
      8'h13, 8'h12: four = 1'b1;
      8'h0B: dum = 1;
      8'h0C: begin dum = 2; four = 1'b1; end
      8'h3B: begin dum = 1; kind = 1; tw = 2; end
      8'h6B: begin dum = 1; kind = 1; tw = 4; end
      8'hA2: begin kind = 1; tw = 2; end
      8'h32: begin kind = 1; tw = 4; end
      8'h34: begin kind = 1; tw = 4; four = 1'b1; end
      8'h3C: begin dum = 1; kind = 1; tw = 2; four = 1'b1; end
      8'h6C: begin dum = 1; kind = 1; tw = 4; four = 1'b1; end
      8'hBB: begin dum = 2; kind = 2; tw = 2; end
      8'hBC: begin dum = 2; kind = 2; tw = 2; four = 1'b1; end
      8'hEB: begin dum = 5; kind = 2; tw = 4; end
      8'hEC: begin dum = 5; kind = 2; tw = 4; four = 1'b1; end
      default: known = 1'b0;
    endcase
    al = (four || ext) ? 4 : 3;
    total_hdr = 1 + al + dum;
    if (k == 0) begin ph = 0; w = 1; end
    else if (!known) begin ph = 4; w = 1; kind = 3; end
    else if (k <= al) begin ph = 1; w = (kind == 2) ? tw : 1; end
    else if (k <= al + dum) begin ph = 2; w = (kind == 2) ? tw : 1; end
    else begin ph = 3; w = (kind != 0) ? tw : 1; end
  endfunction

  task automatic check_byte(input logic [7:0] op, input logic ext, input int k, input bit after_gap);
    int ph, w, kind, hdr;
    string tag;
    model(op, ext, k, ph, w, kind, hdr);
    if (after_gap) tag = "R8";
    else if (ph == 4) tag = "R5";
    else if (ph == 1) tag = "R3";
    else if (ph == 2) tag = "R4";
    else if (ph == 3 && kind == 1) tag = "R6";
    else if (kind == 2) tag = "R7";
    else tag = "R2";
    check(tag, $sformatf("phase op=%h byte=%0d", op, k), phase_o, ph);
    check(tag, $sformatf("width op=%h byte=%0d", op, k), lane_width_o, w);
    check("R2", $sformatf("dummy op=%h byte=%0d", op, k), dummy_o, (ph == 2) ? 1 : 0);
    check("R2", $sformatf("cycles op=%h byte=%0d", op, k), cycles_o, 8 / w);
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk_i);
    byte_valid_i = 1'b1;
    byte_i = b;
    @(negedge clk_i);
    byte_valid_i = 1'b0;
  endtask

  task automatic run_cmd(input logic [7:0] op, input logic ext, input int len, input bit gaps);
    for (int k = 0; k < len; k++) begin
      int g;
      g = gaps ? int'($urandom_range(0, 2)) : 0;
      check_byte(op, ext, k, 1'b0);
      if (g > 0) begin
        repeat (g) @(negedge clk_i);
        check_byte(op, ext, k, 1'b1);
      end
      send((k == 0) ? op : 8'($urandom));
    end
  endtask

  task automatic release_cs();
    @(negedge clk_i);
    cs_active_i = 1'b0;
    @(negedge clk_i);
    check("R1", "phase after release", phase_o, 0);
    check("R1", "width after release", lane_width_o, 1);
    cs_active_i = 1'b1;
  endtask

  logic [7:0] ops [17] = '{8'h03, 8'h0B, 8'h3B, 8'h6B, 8'hBB, 8'hEB, 8'h02, 8'hA2, 8'h32,
                           8'h13, 8'h0C, 8'h3C, 8'h6C, 8'hBC, 8'hEC, 8'h12, 8'h34};

  initial begin
    void'($urandom(32'd20251));
    repeat (3) @(negedge clk_i);
    check("R1", "reset phase", phase_o, 0);
    check("R1", "reset width", lane_width_o, 1);
    rst_ni = 1'b1;

    // bytes with select inactive are ignored
    send(8'hEB);
    check("R1", "ignored byte phase", phase_o, 0);
    check("R1", "ignored byte width", lane_width_o, 1);
    cs_active_i = 1'b1;

    // every opcode, both address settings, no gaps
    for (int i = 0; i < 17; i++) begin
      for (int e = 0; e < 2; e++) begin
        ext_addr_i = e[0];
        run_cmd(ops[i], e[0], 13, 1'b0);
        release_cs();
      end
    end

    // unknown opcodes
    run_cmd(8'h9F, 1'b0, 6, 1'b0);
    release_cs();
    run_cmd(8'hFF, 1'b1, 4, 1'b1);
    release_cs();

    // release before a deferred switch fires: must not leak into next command
    ext_addr_i = 1'b0;
    run_cmd(8'h6B, 1'b0, 3, 1'b0);
    release_cs();
    run_cmd(8'h03, 1'b0, 8, 1'b0);
    release_cs();

    // random mix with idle gaps
    for (int n = 0; n < 80; n++) begin
      logic [7:0] op;
      logic ext;
      op = ($urandom_range(0, 7) == 0) ? 8'($urandom) : ops[$urandom_range(0, 16)];
      ext = 1'($urandom);
      ext_addr_i = ext;
      run_cmd(op, ext, int'($urandom_range(1, 14)), 1'b1);
      release_cs();
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    failures++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule